// File: doc/BRIEF.md
# Paged RAM Bank Mapper

This block sits between a Z80-class processor and a DRAM array that has grown from a 64K base to as many as thirty-two 16K pages. The processor selects a page layout by issuing an I/O write. The mapper keeps the low five bits of the data byte as a layout number. For every memory access it then turns the two top address bits into a physical page number. It also enables one of two column-strobe groups. The lower group serves pages 0 to 15, and the upper group serves pages 16 to 31.

Accesses from the video controller never go through the page layout. They always land in pages 0 to 3, picked by two bank bits that the video controller supplies itself. A build-time parameter selects a reduced 320K fit. In that fit the extended layouts stop at page 19. Any layout above that leaves the 4000h window on page 1 and enables no strobe.

The design has a small internal classification of the current layout, with three modes:

- MODE_BASE covers layouts 0 to 7.
- MODE_EXT covers extended layouts whose page exists.
- MODE_ABSENT covers an extended layout beyond the reduced fit.

Each access is classified in the same cycle; the mode is a decode, not a register. The only stored state is the layout register. It moves from one value to another on the clock edge that ends a qualifying write, and it returns to 0 on reset.

Top module: `ram_bank_mapper`

## Requirements
- R1: After reset the layout is 0: windows 0000h, 4000h, 8000h and C000h map to pages 0, 1, 2 and 3 for CPU accesses.
- R2: A write is taken only when io_wr is high, addr_hi[1] (A15) is 0, and data bits 7 and 6 are both 1. Any other write leaves every CPU mapping unchanged.
- R3: Layouts 0 to 7 map windows 0/1/2/3 to the following pages: layout 0 → 0,1,2,3; layout 1 → 0,1,2,7; layout 2 → 4,5,6,7; layout 3 → 0,3,2,7; layouts 4 to 7 → 0,L,2,3, where L is the layout number.
- R4: Extended layouts L from 8 to 31 map the windows to 0, L, 2, 7.
- R5: Data bit 5 is not decoded. Values E0h to FFh select the same layout as C0h to DFh.
- R6: When video_access is 1, phys_bank equals {3'b000, video_bank}, cas_lo_en is 1 and cas_hi_en is 0, whatever the layout is.
- R7: For CPU accesses, cas_hi_en is 1 exactly when the page is 16 or above. This only happens in window 1 (addr_hi = 2'b01). In every other case cas_lo_en is 1. The two strobes are never both 1.
- R8: With REDUCED_FIT = 1, any layout above 19 maps window 1 to page 1 with both strobes at 0. The other windows follow R4.
- R9: The mapping changes on the clock edge that ends a qualifying write. Before that edge the outputs still reflect the old layout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_wr | input | 1 | CPU I/O write strobe, sampled on the rising edge |
| addr_hi | input | 2 | CPU address bits A15..A14 (A15 also qualifies I/O writes) |
| data | input | 8 | CPU data byte for I/O writes |
| video_access | input | 1 | 1 = current access is from the video controller |
| video_bank | input | 2 | Page bits supplied by the video controller |
| phys_bank | output | 5 | Physical 16K page for the current access |
| cas_lo_en | output | 1 | Enable for the strobe group of pages 0 to 15 |
| cas_hi_en | output | 1 | Enable for the strobe group of pages 16 to 31 |

## Verification
A layout write and a memory decode can fall in the same cycle, because the decode is combinational and runs while the write is still pending. The bench raises io_wr together with a new layout byte and reads the outputs just before the capturing edge. It expects the old layout's pages there and the new layout's pages after the edge. Video accesses are also interleaved while an extended layout is active, so the bench can confirm that the video path and the strobe selection stay unaffected by the high page just written.

// File: rtl/ram_bank_mapper_pkg.sv
package ram_bank_mapper_pkg;

    localparam int BANK_W = 5;
    localparam int WIN_W  = 2;

    typedef enum logic [1:0] {
        MODE_BASE   = 2'd0,
        MODE_EXT    = 2'd1,
        MODE_ABSENT = 2'd2
    } map_mode_e;

    // Page for a base layout (0..7) in a given 16K window.
    function automatic logic [BANK_W-1:0] base_page(input logic [2:0] lay,
                                                    input logic [WIN_W-1:0] win);
        logic [BANK_W-1:0] p;
        unique case (win)
            2'd0: p = (lay == 3'd2) ? 5'd4 : 5'd0;
            2'd1: begin
                unique case (lay)
                    3'd0, 3'd1: p = 5'd1;
                    3'd2:       p = 5'd5;
                    3'd3:       p = 5'd3;
                    default:    p = {2'b00, lay};
                endcase
            end
            2'd2: p = (lay == 3'd2) ? 5'd6 : 5'd2;
            default: p = (lay == 3'd1 || lay == 3'd2 || lay == 3'd3) ? 5'd7 : 5'd3;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/mapper_cfg_reg.sv
module mapper_cfg_reg #(
    parameter int CFG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             io_wr,
    input  logic             a15,
    input  logic [7:0]       data,
    output logic [CFG_W-1:0] cfg_q
);
    logic take;

    always_comb begin
        take = io_wr && !a15 && data[7] && data[6];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (take) begin
            cfg_q <= data[CFG_W-1:0];
        end
    end
endmodule

// File: rtl/mapper_page_decode.sv
module mapper_page_decode
    import ram_bank_mapper_pkg::*;
#(
    parameter bit REDUCED_FIT = 1'b0
) (
    input  logic [BANK_W-1:0] cfg,
    input  logic [WIN_W-1:0]  win,
    input  logic              video_access,
    input  logic [1:0]        video_bank,
    output logic [BANK_W-1:0] page,
    output logic              present,
    output map_mode_e         mode
);
    localparam int LAST_EXT = REDUCED_FIT ? 19 : 31;

    always_comb begin
        if (cfg < BANK_W'(8)) begin
            mode = MODE_BASE;
        end else if (int'(cfg) > LAST_EXT) begin
            mode = MODE_ABSENT;
        end else begin
            mode = MODE_EXT;
        end
    end

    always_comb begin
        page    = '0;
        present = 1'b1;
        if (video_access) begin
            page = {3'b000, video_bank};
        end else begin
            unique case (mode)
                MODE_BASE: page = base_page(cfg[2:0], win);
                MODE_EXT: begin
                    unique case (win)
                        2'd0:    page = 5'd0;
                        2'd1:    page = cfg;
                        2'd2:    page = 5'd2;
                        default: page = 5'd7;
                    endcase
                end
                default: begin
                    unique case (win)
                        2'd0:    page = 5'd0;
                        2'd1:    begin page = 5'd1; present = 1'b0; end
                        2'd2:    page = 5'd2;
                        default: page = 5'd7;
                    endcase
                end
            endcase
        end
    end
endmodule

// File: rtl/mapper_strobe_sel.sv
module mapper_strobe_sel
    import ram_bank_mapper_pkg::*;
(
    input  logic [BANK_W-1:0] page,
    input  logic              present,
    input  logic              video_access,
    input  logic [WIN_W-1:0]  win,
    output logic              cas_lo_en,
    output logic              cas_hi_en
);
    always_comb begin
        cas_hi_en = present && !video_access && (win == 2'd1) && page[BANK_W-1];
        cas_lo_en = present && !page[BANK_W-1];
    end
endmodule

// File: rtl/ram_bank_mapper.sv
module ram_bank_mapper
    import ram_bank_mapper_pkg::*;
#(
    parameter bit REDUCED_FIT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic [1:0]        addr_hi,
    input  logic [7:0]        data,
    input  logic              video_access,
    input  logic [1:0]        video_bank,
    output logic [BANK_W-1:0] phys_bank,
    output logic              cas_lo_en,
    output logic              cas_hi_en
);
    logic [BANK_W-1:0] cfg_q;
    logic              present;
    map_mode_e         mode;

    mapper_cfg_reg #(.CFG_W(BANK_W)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .io_wr (io_wr),
        .a15   (addr_hi[1]),
        .data  (data),
        .cfg_q (cfg_q)
    );

    mapper_page_decode #(.REDUCED_FIT(REDUCED_FIT)) u_dec (
        .cfg          (cfg_q),
        .win          (addr_hi),
        .video_access (video_access),
        .video_bank   (video_bank),
        .page         (phys_bank),
        .present      (present),
        .mode         (mode)
    );

    mapper_strobe_sel u_stb (
        .page         (phys_bank),
        .present      (present),
        .video_access (video_access),
        .win          (addr_hi),
        .cas_lo_en    (cas_lo_en),
        .cas_hi_en    (cas_hi_en)
    );
endmodule

// File: rtl/ram_bank_mapper_chk.sv
module ram_bank_mapper_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       io_wr,
    input logic [1:0] addr_hi,
    input logic [7:0] data,
    input logic       video_access,
    input logic [1:0] video_bank,
    input logic [4:0] cfg_q,
    input logic [4:0] phys_bank,
    input logic       cas_lo_en,
    input logic       cas_hi_en
);
    // R7
    hi_strobe_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cas_hi_en |-> (!video_access && addr_hi == 2'b01 && phys_bank >= 5'd16));

    // R7
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cas_lo_en && cas_hi_en));

    // R6
    video_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        video_access |-> (phys_bank == {3'b000, video_bank} && cas_lo_en && !cas_hi_en));

    // R2
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(io_wr && !addr_hi[1] && data[7] && data[6]) |-> $stable(cfg_q));

    // R4
    ext_top_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!video_access && addr_hi == 2'b11 && cfg_q >= 5'd8) |-> phys_bank == 5'd7);
endmodule

bind ram_bank_mapper ram_bank_mapper_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .io_wr        (io_wr),
    .addr_hi      (addr_hi),
    .data         (data),
    .video_access (video_access),
    .video_bank   (video_bank),
    .cfg_q        (cfg_q),
    .phys_bank    (phys_bank),
    .cas_lo_en    (cas_lo_en),
    .cas_hi_en    (cas_hi_en)
);

// File: tb/ram_bank_mapper_test.sv
module ram_bank_mapper_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       io_wr = 1'b0;
    logic [1:0] addr_hi = 2'b00;
    logic [7:0] data = 8'h00;
    logic       video_access = 1'b0;
    logic [1:0] video_bank = 2'b00;
    logic [4:0] bank_f, bank_r;
    logic       lo_f, hi_f, lo_r, hi_r;

    int n_chk = 0;
    int n_bad = 0;
    int lay_m = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ram_bank_mapper #(.REDUCED_FIT(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .addr_hi(addr_hi), .data(data),
        .video_access(video_access), .video_bank(video_bank),
        .phys_bank(bank_f), .cas_lo_en(lo_f), .cas_hi_en(hi_f));

    ram_bank_mapper #(.REDUCED_FIT(1'b1)) uut_r (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .addr_hi(addr_hi), .data(data),
        .video_access(video_access), .video_bank(video_bank),
        .phys_bank(bank_r), .cas_lo_en(lo_r), .cas_hi_en(hi_r));

    // Reference: {page, lo, hi} packed as 7 bits
    function automatic logic [6:0] ref_map(input int lay, input int win, input bit vid,
                                           input int vb, input bit reduced);
        int pg;
        int rows [4];
        if (vid) return {5'(vb), 1'b1, 1'b0};
        case (lay)
            0: rows = '{0, 1, 2, 3};
            1: rows = '{0, 1, 2, 7};
            2: rows = '{4, 5, 6, 7};
            3: rows = '{0, 3, 2, 7};
            4, 5, 6, 7: rows = '{0, lay, 2, 3};
            default: rows = '{0, lay, 2, 7};
        endcase
        pg = rows[win];
        if (reduced && lay > 19 && win == 1) return {5'd1, 1'b0, 1'b0};
        return {5'(pg), (pg < 16), (pg >= 16)};
    endfunction

    task automatic check(input string req, input logic [6:0] got, input logic [6:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got bank=%0d lo=%0b hi=%0b, expected bank=%0d lo=%0b hi=%0b",
                     req, got[6:2], got[1], got[0], exp[6:2], exp[1], exp[0]);
        end
    endtask

    task automatic probe(input string req, input int win, input bit vid, input int vb);
        addr_hi = 2'(win); video_access = vid; video_bank = 2'(vb);
        #1;
        check({req, " full"}, {bank_f, lo_f, hi_f}, ref_map(lay_m, win, vid, vb, 1'b0));
        check({req, " reduced"}, {bank_r, lo_r, hi_r}, ref_map(lay_m, win, vid, vb, 1'b1));
    endtask

    task automatic sweep(input string req);
        for (int w = 0; w < 4; w++) begin
            probe(req, w, 1'b0, 0);
            probe("R6", w, 1'b1, int'($urandom_range(0, 3)));
        end
    endtask

    // One I/O write; model follows R2/R5 rules
    task automatic io_write(input logic a15, input logic [7:0] val);
        @(negedge clk);
        io_wr = 1'b1; addr_hi = {a15, 1'b0}; data = val; video_access = 1'b0;
        @(negedge clk);
        io_wr = 1'b0;
        if (!a15 && val[7] && val[6]) lay_m = int'(val[4:0]);
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset layout
        sweep("R1");

        // R3 / R4 / R5 / R7 / R8: every layout, bit 5 random
        for (int l = 0; l < 32; l++) begin
            io_write(1'b0, {2'b11, 1'($urandom_range(0, 1)), 5'(l)});
            if (l < 8) sweep("R3");
            else if (l > 19) sweep("R8");
            else sweep("R4");
        end

        // R5: explicit alias E5h vs C5h
        io_write(1'b0, 8'hE5);
        probe("R5", 1, 1'b0, 0);
        io_write(1'b0, 8'hFF);
        probe("R5", 1, 1'b0, 0);
        probe("R7", 0, 1'b0, 0);

        // R2: non-qualifying writes ignored
        io_write(1'b0, 8'hC2);
        io_write(1'b1, 8'hD8);
        sweep("R2");
        io_write(1'b0, 8'h98);
        sweep("R2");
        io_write(1'b0, 8'h5A);
        sweep("R2");
        for (int k = 0; k < 40; k++) begin
            io_write(1'($urandom_range(0, 1)), 8'($urandom));
            sweep("R2");
        end

        // R9: same-cycle write and decode
        io_write(1'b0, 8'hC0);
        @(negedge clk);
        io_wr = 1'b1; addr_hi = 2'b01; data = 8'hDC; video_access = 1'b0;
        #1;
        check("R9 before edge", {bank_f, lo_f, hi_f}, ref_map(0, 1, 1'b0, 0, 1'b0));
        @(negedge clk);
        io_wr = 1'b0;
        lay_m = 28;
        probe("R9", 1, 1'b0, 0);
        probe("R6", 1, 1'b1, 2);
        probe("R7", 3, 1'b0, 0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: got timeout, expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule